// File: doc/BRIEF.md
# Scanline Mode Timing Generator

This block produces the raster timing of a small tile-based display. It is advanced by a dot-clock enable, counts dots across each scanline and scanlines across each frame, and reports which phase the display engine is in: searching objects for the line, transferring pixels, resting in horizontal blank, or resting in vertical blank. Other logic uses the 2-bit phase code to decide when memory may be touched. It uses the single-cycle entry strobes to raise interrupts or to start per-line work.

Each phase has a fixed length. A visible line is split into an object-search phase, a pixel-transfer phase and a horizontal-blank phase. The ten lines after the visible area report vertical blank for their whole length. A display-enable input parks the counters at the frame origin. When that input returns high, timing restarts cleanly from the origin.

All outputs are registered. Counter and phase changes appear one clock after the edge that samples the dot-clock enable high.

Top module: `scan_phase_gen`

## Requirements
- R1: The dot counter steps by one on each advancing cycle, from 0 up to 455, and then returns to 0, so a line is 456 dots long.
- R2: On lines 0 to 143, mode reads 2'b10 (object search) for dots 0–79, 2'b11 (pixel transfer) for dots 80–251 and 2'b00 (horizontal blank) for dots 252–455.
- R3: On lines 144 to 153, mode reads 2'b01 (vertical blank) for every dot of the line.
- R4: The line counter increments when the dot counter wraps. After line 153 it returns to 0, giving 154 lines per frame.
- R5: While display is enabled and running, a cycle with dot_en low changes no output: dot and ly hold, and no strobe fires.
- R6: A cycle sampled with disp_en low sets dot and ly to 0, mode to 2'b00 and all strobes low at the next clock.
- R7: The first cycle sampled with disp_en high after it was low shows line 0, dot 0, mode 2'b10 and a search_go pulse. Counting begins with the next cycle that has dot_en high.
- R8: search_go, xfer_go and hblank_go are each high for exactly one clock. That clock is the one in which a visible line first shows dot 0, dot 80 or dot 252 respectively. At most one strobe is high in any cycle.
- R9: vblank_go is high for one clock when line 144 dot 0 is first shown, and never on lines 145 to 153.
- R10: A synchronous active-high reset clears dot, ly, mode and all strobes at the next clock, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_en | input | 1 | Dot-clock enable; counters advance only when high |
| disp_en | input | 1 | Display enable; low parks timing at the origin |
| mode | output | 2 | Phase code: 00 hblank, 01 vblank, 10 search, 11 transfer |
| ly | output | 8 | Current scanline, 0 to 153 |
| dot | output | 9 | Current dot within the line, 0 to 455 |
| search_go | output | 1 | Pulse on entry to object search |
| xfer_go | output | 1 | Pulse on entry to pixel transfer |
| hblank_go | output | 1 | Pulse on entry to horizontal blank |
| vblank_go | output | 1 | Pulse on entry to vertical blank |

## Verification
Two things can land on one edge. The first is the frame wrap at line 153 dot 455: the line counter returns to 0, the mode leaves vertical blank and the search strobe fires, all in the same cycle. The bench runs more than one full frame with dot_en held high, so it passes through this point. It judges mode, ly, dot and every strobe in the following cycle against a model of its own. The second is a display switch-off on the very cycle that would have entered pixel transfer, at dot 79 with dot_en high. There the bench expects the park to win: zero counters, mode 0 and no xfer_go.

// File: rtl/scan_phase_pkg.sv
package scan_phase_pkg;

  // Phase codes; the numeric values are visible on the mode port.
  typedef enum logic [1:0] {
    PH_HBLANK = 2'b00,
    PH_VBLANK = 2'b01,
    PH_SEARCH = 2'b10,
    PH_XFER   = 2'b11
  } phase_t;

  localparam int NUM_PHASES = 4;

endpackage

// File: rtl/sp_wrap_counter.sv
// Modulo counter with synchronous clear; exposes its next value so that
// downstream decode can be registered in step with the count.
module sp_wrap_counter #(
  parameter int W    = 9,
  parameter int LAST = 455
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         at_last
);

  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_comb begin
    at_last = (cnt == LAST_V);
    if (clr)
      nxt = '0;
    else if (adv)
      nxt = at_last ? '0 : cnt + 1'b1;
    else
      nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else
      cnt <= nxt;
  end

endmodule

// File: rtl/sp_phase_decode.sv
// Maps a (dot, line) position to its phase and flags positions that are
// the first dot of a phase.
module sp_phase_decode
  import scan_phase_pkg::*;
#(
  parameter int DOT_W       = 9,
  parameter int LINE_W      = 8,
  parameter int SEARCH_DOTS = 80,
  parameter int XFER_DOTS   = 172,
  parameter int VIS_LINES   = 144
) (
  input  logic [DOT_W-1:0]      dot,
  input  logic [LINE_W-1:0]     ly,
  output phase_t                phase,
  output logic [NUM_PHASES-1:0] first
);

  localparam logic [DOT_W-1:0]  XFER_AT = DOT_W'(SEARCH_DOTS);
  localparam logic [DOT_W-1:0]  HBL_AT  = DOT_W'(SEARCH_DOTS + XFER_DOTS);
  localparam logic [LINE_W-1:0] VBL_AT  = LINE_W'(VIS_LINES);

  logic visible;

  always_comb begin
    visible = (ly < VBL_AT);

    if (!visible)
      phase = PH_VBLANK;
    else if (dot < XFER_AT)
      phase = PH_SEARCH;
    else if (dot < HBL_AT)
      phase = PH_XFER;
    else
      phase = PH_HBLANK;

    first                 = '0;
    first[int'(PH_SEARCH)] = visible && (dot == '0);
    first[int'(PH_XFER)]   = visible && (dot == XFER_AT);
    first[int'(PH_HBLANK)] = visible && (dot == HBL_AT);
    first[int'(PH_VBLANK)] = (ly == VBL_AT) && (dot == '0);
  end

endmodule

// File: rtl/sp_strobe_bank.sv
// One registered pulse per phase, raised only on cycles where the
// position actually moves onto a phase's first dot.
module sp_strobe_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [N-1:0] hit,
  output logic [N-1:0] go
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= 1'b0;
      else
        q <= fire & hit[i];
    end
    assign go[i] = q;
  end

endmodule

// File: rtl/scan_phase_gen.sv
module scan_phase_gen
  import scan_phase_pkg::*;
#(
  parameter  int DOTS_PER_LINE = 456,
  parameter  int SEARCH_DOTS   = 80,
  parameter  int XFER_DOTS     = 172,
  parameter  int VIS_LINES     = 144,
  parameter  int VBL_LINES     = 10,
  localparam int TOTAL_LINES   = VIS_LINES + VBL_LINES,
  localparam int DOT_W         = $clog2(DOTS_PER_LINE),
  localparam int LINE_W        = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en,
  input  logic              disp_en,
  output logic [1:0]        mode,
  output logic [LINE_W-1:0] ly,
  output logic [DOT_W-1:0]  dot,
  output logic              search_go,
  output logic              xfer_go,
  output logic              hblank_go,
  output logic              vblank_go
);

  logic                  run_q;
  logic                  start;
  logic                  adv;
  logic                  park;
  logic [DOT_W-1:0]      dot_nxt;
  logic [LINE_W-1:0]     ly_nxt;
  logic                  dot_last;
  logic                  ly_last;
  phase_t                phase_nxt;
  logic [NUM_PHASES-1:0] first_nxt;
  logic [NUM_PHASES-1:0] go;
  logic [1:0]            mode_q;

  // Control: park when display is off, present the origin on the first
  // enabled cycle, then count on dot-clock enables.
  assign park  = ~disp_en;
  assign start = disp_en & ~run_q;
  assign adv   = disp_en & run_q & dot_en;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= 1'b0;
    else
      run_q <= disp_en;
  end

  sp_wrap_counter #(
    .W    (DOT_W),
    .LAST (DOTS_PER_LINE - 1)
  ) i_dot_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (park),
    .adv     (adv),
    .cnt     (dot),
    .nxt     (dot_nxt),
    .at_last (dot_last)
  );

  sp_wrap_counter #(
    .W    (LINE_W),
    .LAST (TOTAL_LINES - 1)
  ) i_line_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (park),
    .adv     (adv & dot_last),
    .cnt     (ly),
    .nxt     (ly_nxt),
    .at_last (ly_last)
  );

  sp_phase_decode #(
    .DOT_W       (DOT_W),
    .LINE_W      (LINE_W),
    .SEARCH_DOTS (SEARCH_DOTS),
    .XFER_DOTS   (XFER_DOTS),
    .VIS_LINES   (VIS_LINES)
  ) i_decode (
    .dot   (dot_nxt),
    .ly    (ly_nxt),
    .phase (phase_nxt),
    .first (first_nxt)
  );

  // Phase register is loaded from the next position so it lines up with
  // the counters without an extra cycle of lag.
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= PH_HBLANK;
    else if (park)
      mode_q <= PH_HBLANK;
    else
      mode_q <= phase_nxt;
  end

  sp_strobe_bank #(
    .N (NUM_PHASES)
  ) i_strobes (
    .clk  (clk),
    .rst  (rst),
    .fire (start | adv),
    .hit  (first_nxt),
    .go   (go)
  );

  assign mode      = mode_q;
  assign search_go = go[int'(PH_SEARCH)];
  assign xfer_go   = go[int'(PH_XFER)];
  assign hblank_go = go[int'(PH_HBLANK)];
  assign vblank_go = go[int'(PH_VBLANK)];

  logic unused_ok;
  assign unused_ok = ly_last;

endmodule

// File: rtl/scan_phase_gen_chk.sv
module scan_phase_gen_chk #(
  parameter int DOT_W         = 9,
  parameter int LINE_W        = 8,
  parameter int DOTS_PER_LINE = 456,
  parameter int SEARCH_DOTS   = 80,
  parameter int VIS_LINES     = 144,
  parameter int VBL_LINES     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              dot_en,
  input logic              disp_en,
  input logic [1:0]        mode,
  input logic [LINE_W-1:0] ly,
  input logic [DOT_W-1:0]  dot,
  input logic              search_go,
  input logic              xfer_go,
  input logic              hblank_go,
  input logic              vblank_go,
  input logic              run_q
);

  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  XFER_AT   = DOT_W'(SEARCH_DOTS);
  localparam logic [LINE_W-1:0] VBL_AT    = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(VIS_LINES + VBL_LINES - 1);

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    dot <= DOT_LAST); // R1

  AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && disp_en && dot_en && dot != DOT_LAST) |=> (dot == DOT_W'($past(dot) + 1'b1))); // R1

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    ly <= LINE_LAST); // R4

  AST_VBL_MODE: assert property (@(posedge clk) disable iff (rst)
    (run_q && ly >= VBL_AT) |-> (mode == 2'b01)); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && disp_en && !dot_en) |=> ($stable(dot) && $stable(ly))); // R5

  AST_PARK: assert property (@(posedge clk) disable iff (rst)
    (!disp_en) |=> (dot == '0 && ly == '0 && mode == 2'b00)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({search_go, xfer_go, hblank_go, vblank_go})); // R8

  AST_SEARCH_SHORT: assert property (@(posedge clk) disable iff (rst)
    search_go |=> !search_go); // R8

  AST_XFER_AT: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> (dot == XFER_AT && mode == 2'b11)); // R8

  AST_VBL_GO_AT: assert property (@(posedge clk) disable iff (rst)
    vblank_go |-> (ly == VBL_AT && dot == '0)); // R9

endmodule

bind scan_phase_gen scan_phase_gen_chk #(
  .DOT_W         (DOT_W),
  .LINE_W        (LINE_W),
  .DOTS_PER_LINE (DOTS_PER_LINE),
  .SEARCH_DOTS   (SEARCH_DOTS),
  .VIS_LINES     (VIS_LINES),
  .VBL_LINES     (VBL_LINES)
) i_chk (.*);

// File: tb/test_scan_phase_gen.sv
module test_scan_phase_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dot_en = 1'b0;
  logic       disp_en = 1'b0;
  logic [1:0] mode;
  logic [7:0] ly;
  logic [8:0] dot;
  logic       search_go, xfer_go, hblank_go, vblank_go;

  always #5 clk = ~clk;

  scan_phase_gen i_scan_phase_gen (
    .clk       (clk),
    .rst       (rst),
    .dot_en    (dot_en),
    .disp_en   (disp_en),
    .mode      (mode),
    .ly        (ly),
    .dot       (dot),
    .search_go (search_go),
    .xfer_go   (xfer_go),
    .hblank_go (hblank_go),
    .vblank_go (vblank_go)
  );

  typedef struct {
    int    mode;
    int    ly;
    int    dot;
    int    go;   // bit index = phase code
    int    run;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  // reference state
  int m_run = 0;
  int m_dot = 0;
  int m_ly  = 0;

  function automatic int ref_mode(int r, int d, int l);
    if (!r) return 0;
    if (l >= 144) return 1;
    if (d < 80) return 2;
    if (d < 252) return 3;
    return 0;
  endfunction

  function automatic int ref_entry(int d, int l);
    if (l < 144 && d == 0)   return 4;  // search, code 2
    if (l < 144 && d == 80)  return 8;  // transfer, code 3
    if (l < 144 && d == 252) return 1;  // hblank, code 0
    if (l == 144 && d == 0)  return 2;  // vblank, code 1
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic drive(input logic r, input logic e, input logic d);
    exp_t it;
    int   g;
    @(negedge clk);
    rst = r; dot_en = e; disp_en = d;
    g = 0;
    it.tag = "";
    if (r) begin
      m_run = 0; m_dot = 0; m_ly = 0; it.tag = "R10";
    end else if (!d) begin
      m_run = 0; m_dot = 0; m_ly = 0; it.tag = "R6";
    end else if (!m_run) begin
      m_run = 1; m_dot = 0; m_ly = 0; g = 4; it.tag = "R7";
    end else if (e) begin
      m_dot++;
      if (m_dot == 456) begin
        m_dot = 0;
        m_ly++;
        if (m_ly == 154) m_ly = 0;
      end
      g = ref_entry(m_dot, m_ly);
    end else begin
      it.tag = "R5";
    end
    it.mode = ref_mode(m_run, m_dot, m_ly);
    it.ly   = m_ly;
    it.dot  = m_dot;
    it.go   = g;
    it.run  = m_run;
    q.push_back(it);
  endtask

  // Monitor: compares each clock's result after the edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        int   act_go;
        it = q.pop_front();
        act_go = {xfer_go, search_go, vblank_go, hblank_go};
        check((it.tag != "") ? it.tag : "R1", "dot", int'(dot), it.dot);
        check((it.tag != "") ? it.tag : "R4", "ly", int'(ly), it.ly);
        check((it.tag != "") ? it.tag : ((it.ly >= 144) ? "R3" : "R2"),
              "mode", int'(mode), it.mode);
        check((it.tag != "") ? it.tag : (((it.go | act_go) & 2) != 0 ? "R9" : "R8"),
              "strobes", act_go, it.go);
      end
    end
  end

  // Watchdog
  initial begin
    #(10 * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // R10: reset wins even with display enabled
    drive(1, 0, 0);
    drive(1, 1, 1);
    drive(1, 0, 0);
    // R6: display parked
    for (int i = 0; i < 4; i++) drive(0, 1, 0);
    // R7: start, then sparse dot enables (R5 holds between them)
    drive(0, 1, 1);
    for (int i = 0; i < 1500; i++) drive(0, (i % 3) == 0, 1);
    // R1 R2 R3 R4 R8 R9: more than one full frame at full rate
    for (int i = 0; i < 456 * 154 + 400; i++) drive(0, 1, 1);
    // R6 mid-line, then restart and park on the cycle that would enter transfer
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 1, 1);
    for (int i = 0; i < 79; i++) drive(0, 1, 1);
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(0, 0, 1);
    for (int i = 0; i < 300; i++) drive(0, 1, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule